// File: doc/BRIEF.md
# Key-Protected Refresh Register Bank

This block holds four 16-bit control registers for a memory refresh controller: a refresh count, a control/status register, a refresh counter and a refresh constant. A simple synchronous bus reaches them. It has a byte address, separate write and read strobes, two byte-lane enables, 16-bit write data and 16-bit registered read data. The refresh timer, the refresh command generation and the memory interface are outside this block. It only stores and returns the register fields.

Each write is guarded against accidental overwrites. A write lands only when both byte lanes are enabled and the upper bits of the write data carry a fixed key code. The refresh count register uses a 6-bit key above a 10-bit field. The other three registers use an 8-bit key above an 8-bit field. The block drops every other write and raises a one-cycle error flag for it. Key bits are never stored. Bits that a register does not implement read back as zero.

Top module: `refresh_keyreg_bank`

## Requirements
- R1: After reset, every register field is 0. `rdata` is 0 and `wr_err` is 0.
- R2: Registers decode at byte offsets 0 (refresh count), 2 (control/status), 4 (refresh counter) and 6 (refresh constant) of `addr`.
- R3: A write to offset 2, 4 or 6 is accepted only when `byte_en` is 2'b11 and `wdata[15:8]` is 8'hA5. The register then stores `wdata[7:0]`.
- R4: A write to offset 0 is accepted only when `byte_en` is 2'b11 and `wdata[15:10]` is 6'b101001. The register then stores `wdata[9:0]`.
- R5: A write with any `byte_en` other than 2'b11 leaves every register unchanged, even when the key is correct. Bit 0 of `byte_en` is the lower byte lane.
- R6: When `rd_en` is high at a rising clock edge, `rdata` takes the addressed register's value at that edge. Otherwise `rdata` holds its previous value.
- R7: Unimplemented bits read as 0: bits 15:10 of the refresh count and bits 15:8 of the other registers. A key written with the data never reads back.
- R8: Any offset other than 0, 2, 4 or 6 reads as 0, and a write to such an offset changes no register.
- R9: `wr_err` is high for exactly the one cycle after a rejected write. A write is rejected for a wrong key, a partial lane strobe or an unmapped offset. In every other cycle `wr_err` is low.
- R10: When a read and an accepted write address the same register at the same edge, the read returns the value from before the write. A read on the next edge returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| byte_en | input | 2 | Byte-lane enables, bit 0 is the lower lane |
| wdata | input | 16 | Write data, including the key in the upper bits |
| rdata | output | 16 | Registered read data |
| wr_err | output | 1 | One-cycle flag for a rejected write |

## Verification
The assertions assume that `addr`, `wr_en`, `rd_en` and `byte_en` are never unknown at a clock edge once reset is released. They also assume that reset is low at the first edge, so that the reset property has a defined starting point. The stimulus keeps to these assumptions: it changes inputs only on falling edges, starts with reset asserted and sets every strobe to a known level in each cycle. A read is allowed in the same cycle as a write because R10 defines that case. The stimulus exercises it on purpose instead of avoiding it.

// File: rtl/refbank_pkg.sv
`timescale 1ns/1ps
package refbank_pkg;

    localparam int unsigned DW     = 16;
    localparam int unsigned LANES  = DW / 8;
    localparam int unsigned NREG   = 4;
    localparam int unsigned IDX_W  = $clog2(NREG);
    localparam int unsigned OFFS_W = IDX_W + 1;

    // slot 0 is the refresh count: narrow key, wide field
    localparam int unsigned NARROW_FIELD = 10;
    localparam int unsigned WIDE_FIELD   = 8;
    localparam logic [DW-1:0] NARROW_KEY = 16'h0029; // 6'b101001
    localparam logic [DW-1:0] WIDE_KEY   = 16'h00A5;

    typedef enum logic [IDX_W-1:0] {
        SLOT_RCOUNT = 2'd0,
        SLOT_CTRL   = 2'd1,
        SLOT_TIMER  = 2'd2,
        SLOT_LIMIT  = 2'd3
    } slot_e;

    function automatic int unsigned field_w(int unsigned slot);
        return (slot == int'(SLOT_RCOUNT)) ? NARROW_FIELD : WIDE_FIELD;
    endfunction

    function automatic logic [DW-1:0] key_of(int unsigned slot);
        return (slot == int'(SLOT_RCOUNT)) ? NARROW_KEY : WIDE_KEY;
    endfunction

    function automatic logic [DW-1:0] mask_of(int unsigned slot);
        return DW'((32'd1 << field_w(slot)) - 32'd1);
    endfunction

endpackage

// File: rtl/refbank_decode.sv
`timescale 1ns/1ps
module refbank_decode
    import refbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [LANES-1:0]  byte_en,
    input  logic [DW-1:0]     wdata,
    output logic              map_hit,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              wr_accept,
    output logic              wr_reject
);

    logic [NREG-1:0] key_match;
    logic            full_word;

    // every slot checks its own key above its own field width
    for (genvar g = 0; g < NREG; g++) begin : g_key
        localparam int unsigned FW = field_w(g);
        always_comb begin
            key_match[g] = ((wdata >> FW) == key_of(g));
        end
    end

    always_comb begin
        map_hit   = (addr[0] == 1'b0) && ((addr >> OFFS_W) == '0);
        sel_idx   = addr[OFFS_W-1:1];
        full_word = &byte_en;
        wr_accept = wr_en && map_hit && full_word && key_match[sel_idx];
        wr_reject = wr_en && !wr_accept;
    end

endmodule

// File: rtl/refbank_store.sv
`timescale 1ns/1ps
module refbank_store
    import refbank_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_accept,
    input  logic [IDX_W-1:0]          sel_idx,
    input  logic [DW-1:0]             wdata,
    output logic [NREG-1:0][DW-1:0]   bank
);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int unsigned i = 0; i < NREG; i++) begin
            if (wr_accept && (sel_idx == IDX_W'(i))) begin
                st_d.regs[i] = wdata & mask_of(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank = st_q.regs;

endmodule

// File: rtl/refbank_rdport.sv
`timescale 1ns/1ps
module refbank_rdport
    import refbank_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic                      map_hit,
    input  logic [IDX_W-1:0]          sel_idx,
    input  logic [NREG-1:0][DW-1:0]   bank,
    input  logic                      wr_reject,
    output logic [DW-1:0]             rdata,
    output logic                      wr_err
);

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          err;
    } port_t;

    port_t pt_d, pt_q;

    always_comb begin
        pt_d     = pt_q;
        pt_d.err = wr_reject;
        if (rd_en) begin
            pt_d.rdata = map_hit ? bank[sel_idx] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    assign rdata  = pt_q.rdata;
    assign wr_err = pt_q.err;

endmodule

// File: rtl/refresh_keyreg_bank.sv
`timescale 1ns/1ps
module refresh_keyreg_bank
    import refbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        byte_en,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              wr_err
);

    logic                    map_hit;
    logic [IDX_W-1:0]        sel_idx;
    logic                    wr_accept;
    logic                    wr_reject;
    logic [NREG-1:0][DW-1:0] bank;

    refbank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (addr),
        .wr_en     (wr_en),
        .byte_en   (byte_en),
        .wdata     (wdata),
        .map_hit   (map_hit),
        .sel_idx   (sel_idx),
        .wr_accept (wr_accept),
        .wr_reject (wr_reject)
    );

    refbank_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .sel_idx   (sel_idx),
        .wdata     (wdata),
        .bank      (bank)
    );

    refbank_rdport u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .map_hit   (map_hit),
        .sel_idx   (sel_idx),
        .bank      (bank),
        .wr_reject (wr_reject),
        .rdata     (rdata),
        .wr_err    (wr_err)
    );

endmodule

// File: rtl/refbank_checker.sv
`timescale 1ns/1ps
module refbank_checker #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        byte_en,
    input logic [15:0]       rdata,
    input logic              wr_err,
    input logic              wr_accept
);

    logic unmapped;
    assign unmapped = addr[0] || ((addr >> 3) != '0);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rdata == 16'h0 && !wr_err));

    p_reject_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_accept) |=> wr_err);

    p_quiet_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_accept) |=> !wr_err);

    p_partial_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && byte_en != 2'b11) |=> wr_err);

    p_hold_rdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped) |=> (rdata == 16'h0));

    p_unmapped_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unmapped) |-> !wr_accept);

    p_count_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == '0) |=> (rdata[15:10] == 6'h0));

    p_byte_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !unmapped && addr != '0) |=> (rdata[15:8] == 8'h0));

endmodule

bind refresh_keyreg_bank refbank_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .byte_en   (byte_en),
    .rdata     (rdata),
    .wr_err    (wr_err),
    .wr_accept (wr_accept)
);

// File: tb/refresh_keyreg_bank_test.sv
`timescale 1ns/1ps
module refresh_keyreg_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  byte_en = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        wr_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] exp_rd;
        bit          exp_err;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [15:0] model [4];
    logic [15:0] last_rd = '0;

    always #2 clk = ~clk;

    refresh_keyreg_bank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .byte_en(byte_en), .wdata(wdata), .rdata(rdata), .wr_err(wr_err)
    );

    task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit mapped(logic [3:0] a);
        return (a == 4'd0) || (a == 4'd2) || (a == 4'd4) || (a == 4'd6);
    endfunction

    function automatic bit key_good(logic [3:0] a, logic [15:0] d);
        if (a == 4'd0) return d[15:10] == 6'b101001;
        return d[15:8] == 8'hA5;
    endfunction

    // one bus cycle; the model is updated after the read value is taken
    task automatic cycle(logic [3:0] a, bit w, bit r, logic [1:0] be,
                         logic [15:0] d, string tag);
        item_t it;
        bit ok;
        @(negedge clk);
        addr = a; wr_en = w; rd_en = r; byte_en = be; wdata = d;
        if (r) last_rd = mapped(a) ? model[a[2:1]] : 16'h0;
        ok = w && mapped(a) && (be == 2'b11) && key_good(a, d);
        if (ok) model[a[2:1]] = (a == 4'd0) ? {6'h0, d[9:0]} : {8'h0, d[7:0]};
        it.exp_rd = last_rd;
        it.exp_err = w && !ok;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(logic [3:0] a, logic [1:0] be, logic [15:0] d, string tag);
        cycle(a, 1'b1, 1'b0, be, d, tag);
    endtask

    task automatic rd(logic [3:0] a, string tag);
        cycle(a, 1'b0, 1'b1, 2'b00, 16'h0, tag);
    endtask

    task automatic idle(string tag);
        cycle(4'd0, 1'b0, 1'b0, 2'b00, 16'h0, tag);
    endtask

    // monitor: one item per bus cycle, checked just after the edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check(rdata == it.exp_rd, {it.tag, " rdata"}, rdata, it.exp_rd);
                check(wr_err == it.exp_err, {it.tag, " wr_err"},
                      {15'h0, wr_err}, {15'h0, it.exp_err});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(rdata == 16'h0, "R1 reset rdata", rdata, 16'h0);
        check(wr_err == 1'b0, "R1 reset wr_err", {15'h0, wr_err}, 16'h0);

        // R1: every slot reads zero after reset
        for (int i = 0; i < 4; i++) rd(4'(2 * i), "R1 reset read");

        // R4, R7: count register, narrow key, only 10 bits kept
        wr(4'd0, 2'b11, 16'hA7FF, "R4 write count");
        rd(4'd0, "R4 R7 count readback");
        // R3, R2: each 8-bit-key slot at its own offset
        wr(4'd2, 2'b11, 16'hA55A, "R3 write ctrl");
        wr(4'd4, 2'b11, 16'hA5C3, "R3 write timer");
        wr(4'd6, 2'b11, 16'hA5FF, "R3 write limit");
        rd(4'd2, "R2 ctrl readback");
        rd(4'd4, "R2 timer readback");
        rd(4'd6, "R7 key not returned");

        // R3, R9: wrong keys rejected, flag for one cycle only
        wr(4'd2, 2'b11, 16'hA45A, "R9 wrong wide key");
        idle("R9 flag drops");
        wr(4'd0, 2'b11, 16'hA800, "R4 wrong narrow key");
        wr(4'd4, 2'b11, 16'h2900, "R3 narrow key on wide slot");
        rd(4'd2, "R3 ctrl kept");
        rd(4'd0, "R4 count kept");
        rd(4'd4, "R3 timer kept");

        // R5: partial lane strobes
        wr(4'd6, 2'b01, 16'hA511, "R5 low lane only");
        wr(4'd6, 2'b10, 16'hA522, "R5 high lane only");
        wr(4'd0, 2'b00, 16'hA400, "R5 no lanes");
        rd(4'd6, "R5 limit kept");
        rd(4'd0, "R5 count kept");

        // R8: unmapped offsets
        wr(4'd8, 2'b11, 16'hA533, "R8 write high offset");
        wr(4'd3, 2'b11, 16'hA544, "R8 write odd offset");
        rd(4'd8, "R8 read high offset");
        rd(4'd2, "R8 ctrl kept");
        rd(4'd3, "R8 read odd offset");
        rd(4'd14, "R8 read top offset");
        for (int i = 0; i < 4; i++) rd(4'(2 * i), "R8 bank intact");

        // R6: read data holds with no read strobe
        rd(4'd4, "R6 read timer");
        idle("R6 hold one");
        wr(4'd6, 2'b11, 16'hA501, "R6 hold across write");
        idle("R6 hold two");

        // R10: read and write to the same slot at one edge
        cycle(4'd2, 1'b1, 1'b1, 2'b11, 16'hA577, "R10 old value on collision");
        rd(4'd2, "R10 new value next");
        cycle(4'd0, 1'b1, 1'b1, 2'b11, 16'hA6AA, "R10 count collision");
        rd(4'd0, "R10 count new value");
        idle("end");
        idle("end");

        repeat (3) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule